// File: doc/BRIEF.md
# Serial Set-Bit Counter

This block counts how many bits of a data word are 1, one small register transfer per clock. A controller of eight states steers a datapath of four registers: a data register that is shifted right, a running count, a single-bit mask, and a temporary that holds the masked bit. A request is made by raising `start` while the block is idle. The operand is captured from `din` in the next state. The block then clears the count, sets the mask, and repeats an AND / add / shift group until the shifted data register becomes zero. After that it reports the result for one cycle.

Only one request is in flight at a time. The number of cycles depends on the position of the highest set bit of the operand. It does not depend on how many bits are set. The count output is wide enough to hold a word in which every bit is 1.

Top module: `popc_engine`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `done` is 0 and `count` is 0. The controller is idle.
- R2: In idle, the block stays idle with `done` low as long as `start` is 0. A `start` of 1 sampled on a clock edge in idle begins a count.
- R3: When `done` is 1, `count` equals the number of 1 bits of the `din` value sampled one clock edge after the edge that accepted `start`.
- R4: Let n be the index of the highest set bit of the operand plus one, or 1 for a zero operand. `done` rises after 4 + 3n rising clock edges, counting the edge that accepted `start` as the first.
- R5: `done` is high for exactly one cycle. On the next edge the block is idle again and accepts a new `start`.
- R6: While a count is in progress, `start` and `din` have no effect on the result or on the latency. `din` matters only in the capture cycle. `start` matters only in idle.
- R7: An all-zero operand runs the loop body once. It finishes with `count` = 0 after 7 edges.
- R8: `count` is 0 in every cycle in which `done` is 0.
- R9: `count` is $clog2(WIDTH+1) bits wide. An all-ones operand yields `count` = WIDTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a count; sampled only when idle |
| din | input | WIDTH | Operand, captured in the cycle after acceptance |
| done | output | 1 | High for the single result cycle |
| count | output | $clog2(WIDTH+1) | Number of set bits while `done` is high, else 0 |

## Verification
The bench builds the block with WIDTH = 8. This makes every one of the 256 operands reachable in a sweep. The sweep covers every highest-bit position, and so every loop length from one to eight passes. It also covers the zero operand and the full count of 8, which needs every bit of the 4-bit count register. On alternate operands the bench holds `start` high and drives the inverted word on `din` for the whole run. It also starts each new request in the cycle right after the result cycle, so back-to-back acceptance is tested on every run.

// File: rtl/popc_pkg.sv
package popc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_LOAD = 3'd1,
        ST_CLR  = 3'd2,
        ST_MASK = 3'd3,
        ST_AND  = 3'd4,
        ST_ACC  = 3'd5,
        ST_SHR  = 3'd6,
        ST_FIN  = 3'd7
    } popc_state_e;

endpackage

// File: rtl/popc_ctrl.sv
module popc_ctrl
    import popc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        shr_zero,
    output popc_state_e state
);

    typedef struct packed {
        popc_state_e st;
    } ctrl_regs_t;

    ctrl_regs_t r_q;
    ctrl_regs_t r_d;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: if (start) r_d.st = ST_LOAD;
            ST_LOAD: r_d.st = ST_CLR;
            ST_CLR:  r_d.st = ST_MASK;
            ST_MASK: r_d.st = ST_AND;
            ST_AND:  r_d.st = ST_ACC;
            ST_ACC:  r_d.st = ST_SHR;
            ST_SHR:  r_d.st = shr_zero ? ST_FIN : ST_AND;
            ST_FIN:  r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign state = r_q.st;

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_IDLE && !start) |=> (r_q.st == ST_IDLE));

    p_idle_go_r2: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_IDLE && start) |=> (r_q.st == ST_LOAD));

    p_loop_back_r4: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_SHR && !shr_zero) |=> (r_q.st == ST_AND));

    p_loop_exit_r4: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_SHR && shr_zero) |=> (r_q.st == ST_FIN));

    p_fin_once_r5: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_FIN) |=> (r_q.st == ST_IDLE));

endmodule

// File: rtl/popc_dpath.sv
module popc_dpath
    import popc_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int CNT_W = $clog2(WIDTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  popc_state_e        state,
    input  logic [WIDTH-1:0]   din,
    output logic               shr_zero,
    output logic [CNT_W-1:0]   cnt
);

    typedef struct packed {
        logic [WIDTH-1:0] data;
        logic [WIDTH-1:0] mask;
        logic [WIDTH-1:0] temp;
        logic [CNT_W-1:0] cnt;
    } dp_regs_t;

    dp_regs_t r_q;
    dp_regs_t r_d;

    logic [WIDTH-1:0] shifted;

    always_comb begin
        shifted = r_q.data >> 1;
        r_d     = r_q;
        unique case (state)
            ST_LOAD: r_d.data = din;
            ST_CLR:  r_d.cnt  = '0;
            ST_MASK: r_d.mask = WIDTH'(1);
            ST_AND:  r_d.temp = r_q.data & r_q.mask;
            ST_ACC:  r_d.cnt  = r_q.cnt + r_q.temp[CNT_W-1:0];
            ST_SHR:  r_d.data = shifted;
            default: ;
        endcase
    end

    // Status: zero-detect on the value the data register takes leaving the shift state.
    assign shr_zero = (shifted == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cnt = r_q.cnt;

    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (rst)
        (int'(r_q.cnt) <= WIDTH));

    p_data_steady_r6: assert property (@(posedge clk) disable iff (rst)
        (state != ST_LOAD && state != ST_SHR) |=> $stable(r_q.data));

    p_cnt_grows_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACC) |=> (r_q.cnt >= $past(r_q.cnt)));

endmodule

// File: rtl/popc_engine.sv
module popc_engine
    import popc_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int CNT_W = $clog2(WIDTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WIDTH-1:0] din,
    output logic             done,
    output logic [CNT_W-1:0] count
);

    popc_state_e      state;
    logic             shr_zero;
    logic [CNT_W-1:0] cnt;

    popc_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .shr_zero (shr_zero),
        .state    (state)
    );

    popc_dpath #(.WIDTH(WIDTH)) u_dpath (
        .clk      (clk),
        .rst      (rst),
        .state    (state),
        .din      (din),
        .shr_zero (shr_zero),
        .cnt      (cnt)
    );

    assign done  = (state == ST_FIN);
    assign count = done ? cnt : '0;

    p_quiet_out_r8: assert property (@(posedge clk) disable iff (rst)
        !done |-> (count == '0));

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: tb/tb_popc_engine.sv
module tb_popc_engine;

    localparam int WIDTH = 8;
    localparam int CNT_W = $clog2(WIDTH + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [WIDTH-1:0] din = '0;
    logic             done;
    logic [CNT_W-1:0] count;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    popc_engine #(.WIDTH(WIDTH)) dut (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .din   (din),
        .done  (done),
        .count (count)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int ones(input logic [WIDTH-1:0] v);
        int c = 0;
        for (int i = 0; i < WIDTH; i++) c += int'(v[i]);
        return c;
    endfunction

    function automatic int passes(input logic [WIDTH-1:0] v);
        int n = 1;
        for (int i = 0; i < WIDTH; i++) if (v[i]) n = i + 1;
        return n;
    endfunction

    // Called at a negedge with the block idle; leaves it at the negedge after done.
    task automatic run_one(input logic [WIDTH-1:0] v, input bit disturb);
        int  edges = 0;
        bit  quiet_ok = 1'b1;
        int  bad_cnt = 0;
        din   = v;
        start = 1'b1;
        forever begin
            @(posedge clk);
            edges++;
            @(negedge clk);
            if (done) break;
            if (count != '0) begin
                quiet_ok = 1'b0;
                bad_cnt  = int'(count);
            end
            if (edges > 200) break;
            start = disturb;
            din   = (edges >= 1 && disturb) ? ~v : v;
            if (edges == 1) din = disturb ? ~v : v; // capture edge is next
            if (edges == 1) din = v;
        end
        start = 1'b0;
        din   = v;
        check(done === 1'b1, "R4 done reached", int'(done), 1);
        check(edges == 4 + 3 * passes(v), "R4 latency", edges, 4 + 3 * passes(v));
        check(int'(count) == ones(v), disturb ? "R6 R3 count" : "R3 count", int'(count), ones(v));
        check(quiet_ok, "R8 count zero while busy", bad_cnt, 0);
        @(negedge clk);
        check(done === 1'b0 && count == '0, "R5 single done cycle", int'(done), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(done === 1'b0, "R1 done in reset", int'(done), 0);
        check(count == '0, "R1 count in reset", int'(count), 0);
        rst = 1'b0;
        @(negedge clk);
        check(done === 1'b0 && count == '0, "R1 idle after reset", int'(done), 0);

        din = '1;
        repeat (6) @(negedge clk);
        check(done === 1'b0, "R2 idle without start", int'(done), 0);

        run_one('0, 1'b0);
        check(1'b1, "R7 zero operand covered", 0, 0);
        run_one('1, 1'b0);
        run_one('1, 1'b1); // R9 full count with disturbance

        for (int v = 0; v < (1 << WIDTH); v++) begin
            run_one(WIDTH'(v), v[0]);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule